// File: doc/BRIEF.md
# Branch Redirect Resolver

This unit sits in the decode/execute boundary of a 32-bit RISC pipeline that has one branch delay slot. Each cycle in which `in_valid` is high it looks at an instruction word, the address of that instruction's delay slot, and the two source operand values already read from the register file. It classifies the word as a branch or jump (or neither) and evaluates the branch condition. It then produces the address the fetch stage must continue from once the delay slot has issued.

Alongside the redirect it produces the return-address write that linking forms need: an enable, a destination register index and the value. Register-indirect jumps whose target is not word aligned raise an address-error flag and report the offending address instead of redirecting. All results are computed combinationally and captured in one output register stage, so they appear one clock after the input is presented.

Instruction fields used: opcode in bits [31:26], rt selector in [20:16], rd in [15:11], function code in [5:0], 16-bit immediate in [15:0], 26-bit jump field in [25:0].

Top module: `branch_resolve`

## Requirements
- R1: While `rst_n` is low, and after it until the first accepted input, `out_valid`, `is_branch`, `taken`, `link_we`, `addr_err` are 0 and `next_pc`, `link_idx`, `link_value`, `bad_addr` are 0.
- R2: Outputs are registered: a word presented with `in_valid` high appears on the outputs after the next rising edge with `out_valid` high; a cycle with `in_valid` low gives `out_valid` low and leaves every other output unchanged.
- R3: `is_branch` is 1 exactly when the opcode is 1 to 7, or when the word ANDed with 0xFC00003E equals 0x00000008 (opcode 0, function code 8 or 9: register jumps); otherwise `taken` and `link_we` are 0.
- R4: For opcodes 1, 4, 5, 6, 7 the target is the delay-slot address plus the sign-extended immediate multiplied by 4, with 32-bit wraparound.
- R5: For opcodes 2 and 3 the target is bits [31:28] of the delay-slot address followed by the 26-bit jump field and two zero bits; the jump is always taken.
- R6: Opcode 3, and opcode 1 with rt equal to 0x10 or 0x11, raise `link_we` with `link_idx` 31 whether or not the branch is taken; the condition uses the operand value as presented. `link_value` always equals the delay-slot address plus 4, and `link_idx` is 0 when `link_we` is low.
- R7: Opcode 0 function 9 jumps to the rs operand and links into rd (`link_idx` = rd) unless rd is 0, in which case no link is written; function 8 jumps without linking.
- R8: For opcode 1 every rt value other than 0x10 and 0x11 is a non-linking branch: on rs >= 0 (signed) when rt bit 0 is 1, on rs < 0 (signed) when it is 0. 0x10 tests rs < 0 and 0x11 tests rs >= 0.
- R9: Opcode 6 is taken when rs <= 0 and opcode 7 when rs > 0, both signed; opcode 4 is taken when all 32 bits of rs and rt match and opcode 5 when any bit differs.
- R10: A register jump whose rs operand has a nonzero low two bits sets `addr_err` and `bad_addr` = rs operand, forces `taken` and `link_we` to 0 and `next_pc` to the fall-through address; otherwise `addr_err` and `bad_addr` are 0.
- R11: When `taken` is 0, `next_pc` equals the delay-slot address plus 4; when `taken` is 1 it equals the target of R4, R5 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| ds_pc | input | 32 | Address of the instruction's delay slot |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| out_valid | output | 1 | Registered results belong to an accepted input |
| is_branch | output | 1 | The word is a branch or jump |
| taken | output | 1 | Control flow is redirected |
| next_pc | output | 32 | Address fetch continues from after the delay slot |
| link_we | output | 1 | Return-address write requested |
| link_idx | output | 5 | Destination register of the return address |
| link_value | output | 32 | Return address (delay-slot address plus 4) |
| addr_err | output | 1 | Misaligned register-jump target |
| bad_addr | output | 32 | Offending target when `addr_err` is high |

## Verification
The return-address write and the misalignment fault can both be triggered by one register jump with link: a linking jump with a nonzero rd and an operand whose low bits are nonzero asks for both at once. The bench applies exactly that word and judges that the fault wins: `addr_err` high with the operand on `bad_addr`, no link write, no redirect and the fall-through address on `next_pc`. The same word with an aligned operand is applied beside it, so the link path is shown to be live and suppressed only by the fault.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam int XW     = 32;
  localparam int RW     = 5;
  localparam int OPW    = 6;
  localparam int IMMW   = 16;
  localparam int JFW    = 26;
  localparam int REGION = XW - JFW - 2;
  localparam logic [RW-1:0] RA_IDX = RW'(31);

  typedef enum logic [2:0] {
    K_NONE, K_REGJ, K_ZCMP, K_JABS, K_EQ, K_NE, K_LEZ, K_GTZ
  } kind_e;

  function automatic logic [XW-1:0] seq_pc(input logic [XW-1:0] ds);
    return ds + XW'(4);
  endfunction

  function automatic logic [XW-1:0] rel_target(input logic [XW-1:0] ds,
                                               input logic [IMMW-1:0] imm);
    return ds + {{(XW-IMMW-2){imm[IMMW-1]}}, imm, 2'b00};
  endfunction

  function automatic logic [XW-1:0] abs_target(input logic [XW-1:0] ds,
                                               input logic [JFW-1:0] jf);
    return {ds[XW-1 -: REGION], jf, 2'b00};
  endfunction

  function automatic logic misaligned(input logic [XW-1:0] t);
    return |t[1:0];
  endfunction
endpackage

// File: rtl/brr_decode.sv
module brr_decode
  import brr_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [RW-1:0]  rt_sel,
  input  logic [RW-1:0]  rd,
  input  logic [5:0]     funct,
  output kind_e          kind,
  output logic           link_ra,
  output logic           link_rd,
  output logic           ge_sel
);
  localparam logic [RW-1:0] LT_LINK = RW'(5'h10);
  localparam logic [RW-1:0] GE_LINK = RW'(5'h11);

  logic regj;
  assign regj = (funct[5:1] == 5'b00100);

  always_comb begin
    kind    = K_NONE;
    link_ra = 1'b0;
    link_rd = 1'b0;
    ge_sel  = 1'b0;
    case (op)
      OPW'(0): begin
        if (regj) begin
          kind    = K_REGJ;
          link_rd = funct[0] && (rd != '0);
        end
      end
      OPW'(1): begin
        kind    = K_ZCMP;
        ge_sel  = rt_sel[0];
        link_ra = (rt_sel == LT_LINK) || (rt_sel == GE_LINK);
      end
      OPW'(2): kind = K_JABS;
      OPW'(3): begin
        kind    = K_JABS;
        link_ra = 1'b1;
      end
      OPW'(4): kind = K_EQ;
      OPW'(5): kind = K_NE;
      OPW'(6): kind = K_LEZ;
      OPW'(7): kind = K_GTZ;
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/brr_cond.sv
module brr_cond
  import brr_pkg::*;
(
  input  kind_e         kind,
  input  logic          ge_sel,
  input  logic [XW-1:0] rs_val,
  input  logic [XW-1:0] rt_val,
  output logic          cond
);
  logic neg, zero;
  assign neg  = rs_val[XW-1];
  assign zero = (rs_val == '0);

  always_comb begin
    case (kind)
      K_REGJ, K_JABS: cond = 1'b1;
      K_ZCMP:         cond = ge_sel ? !neg : neg;
      K_EQ:           cond = (rs_val == rt_val);
      K_NE:           cond = (rs_val != rt_val);
      K_LEZ:          cond = neg || zero;
      K_GTZ:          cond = !neg && !zero;
      default:        cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/brr_target.sv
module brr_target
  import brr_pkg::*;
(
  input  kind_e          kind,
  input  logic [JFW-1:0] jfield,
  input  logic [XW-1:0]  ds_pc,
  input  logic [XW-1:0]  rs_val,
  output logic [XW-1:0]  target
);
  always_comb begin
    case (kind)
      K_REGJ:  target = rs_val;
      K_JABS:  target = abs_target(ds_pc, jfield);
      default: target = rel_target(ds_pc, jfield[IMMW-1:0]);
    endcase
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import brr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [31:0]   ds_pc,
  input  logic [31:0]   rs_val,
  input  logic [31:0]   rt_val,
  output logic          out_valid,
  output logic          is_branch,
  output logic          taken,
  output logic [31:0]   next_pc,
  output logic          link_we,
  output logic [4:0]    link_idx,
  output logic [31:0]   link_value,
  output logic          addr_err,
  output logic [31:0]   bad_addr
);
  kind_e         kind;
  logic          link_ra, link_rd, ge_sel, cond;
  logic [XW-1:0] target;

  brr_decode u_dec (
    .op      (instr[31:26]),
    .rt_sel  (instr[20:16]),
    .rd      (instr[15:11]),
    .funct   (instr[5:0]),
    .kind    (kind),
    .link_ra (link_ra),
    .link_rd (link_rd),
    .ge_sel  (ge_sel)
  );

  brr_cond u_cond (
    .kind   (kind),
    .ge_sel (ge_sel),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .cond   (cond)
  );

  brr_target u_tgt (
    .kind   (kind),
    .jfield (instr[JFW-1:0]),
    .ds_pc  (ds_pc),
    .rs_val (rs_val),
    .target (target)
  );

  // named internal events
  logic          fault_c, taken_c, link_c, branch_c;
  logic [XW-1:0] next_c;
  logic [RW-1:0] idx_c;

  assign branch_c = (kind != K_NONE);
  assign fault_c  = (kind == K_REGJ) && misaligned(rs_val);
  assign taken_c  = cond && !fault_c;
  assign link_c   = (link_ra || link_rd) && !fault_c;
  assign next_c   = taken_c ? target : seq_pc(ds_pc);
  assign idx_c    = !link_c ? '0 : (link_ra ? RA_IDX : instr[15:11]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      is_branch  <= 1'b0;
      taken      <= 1'b0;
      next_pc    <= '0;
      link_we    <= 1'b0;
      link_idx   <= '0;
      link_value <= '0;
      addr_err   <= 1'b0;
      bad_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_branch  <= branch_c;
        taken      <= taken_c;
        next_pc    <= next_c;
        link_we    <= link_c;
        link_idx   <= idx_c;
        link_value <= seq_pc(ds_pc);
        addr_err   <= fault_c;
        bad_addr   <= fault_c ? rs_val : '0;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(next_pc) && $stable(link_we) && !out_valid));

  a_r3_taken_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_branch) |-> (!taken && !link_we));

  a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && link_we) |-> (link_value == $past(ds_pc) + 32'd4));

  a_r7_link_not_r0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && link_we) |-> (link_idx != '0));

  a_r10_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && addr_err) |-> (!taken && !link_we && bad_addr[1:0] != 2'b00));

  a_r11_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> (next_pc == $past(ds_pc) + 32'd4));
endmodule

// File: tb/branch_resolve_bench.sv
`timescale 1ns/1ps
module branch_resolve_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, ds_pc = '0, rs_val = '0, rt_val = '0;
  logic        out_valid, is_branch, taken, link_we, addr_err;
  logic [31:0] next_pc, link_value, bad_addr;
  logic [4:0]  link_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  branch_resolve u_branch_resolve (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .ds_pc(ds_pc), .rs_val(rs_val), .rt_val(rt_val),
    .out_valid(out_valid), .is_branch(is_branch), .taken(taken),
    .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx),
    .link_value(link_value), .addr_err(addr_err), .bad_addr(bad_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] w_i(input int op, input int rt, input logic [15:0] imm);
    return {6'(op), 5'd3, 5'(rt), imm};
  endfunction
  function automatic logic [31:0] w_r(input int fn, input int rd, input logic [4:0] mid);
    return {6'd0, 5'd4, 5'd0, 5'(rd), mid, 6'(fn)};
  endfunction

  // independent reference, written from the requirements
  task automatic expect_of(input logic [31:0] w, input logic [31:0] ds,
                           input logic [31:0] a, input logic [31:0] b,
                           output logic e_br, output logic e_tk, output logic e_we,
                           output logic [4:0] e_idx, output logic [31:0] e_nxt,
                           output logic e_err, output logic [31:0] e_bad);
    int op;
    int rt;
    int rd;
    int fn;
    logic [31:0] fall, tgt, offs;
    op = int'(w[31:26]); rt = int'(w[20:16]); rd = int'(w[15:11]); fn = int'(w[5:0]);
    fall = ds + 32'd4;
    offs = 32'($signed(w[15:0]));
    tgt  = ds + offs * 32'd4;
    e_br = 0; e_tk = 0; e_we = 0; e_idx = 0; e_err = 0; e_bad = 0;
    if (op == 1) begin
      e_br = 1;
      e_tk = (rt % 2 == 1) ? ($signed(a) >= 0) : ($signed(a) < 0);
      if (rt == 16 || rt == 17) begin e_we = 1; e_idx = 31; end
    end else if (op == 2 || op == 3) begin
      e_br = 1; e_tk = 1;
      tgt = (ds & 32'hF000_0000) | ({6'd0, w[25:0]} << 2);
      if (op == 3) begin e_we = 1; e_idx = 31; end
    end else if (op >= 4 && op <= 7) begin
      e_br = 1;
      case (op)
        4: e_tk = (a == b);
        5: e_tk = (a != b);
        6: e_tk = ($signed(a) <= 0);
        default: e_tk = ($signed(a) > 0);
      endcase
    end else if (op == 0 && (fn == 8 || fn == 9)) begin
      e_br = 1; tgt = a;
      if (a % 4 != 0) begin
        e_err = 1; e_bad = a;
      end else begin
        e_tk = 1;
        if (fn == 9 && rd != 0) begin e_we = 1; e_idx = 5'(rd); end
      end
    end
    e_nxt = e_tk ? tgt : fall;
  endtask

  task automatic apply(input string req, input logic [31:0] w, input logic [31:0] ds,
                       input logic [31:0] a, input logic [31:0] b);
    logic e_br, e_tk, e_we, e_err;
    logic [4:0] e_idx;
    logic [31:0] e_nxt, e_bad;
    expect_of(w, ds, a, b, e_br, e_tk, e_we, e_idx, e_nxt, e_err, e_bad);
    @(negedge clk);
    instr = w; ds_pc = ds; rs_val = a; rt_val = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "is_branch", 32'(is_branch), 32'(e_br));
    chk(req, "taken", 32'(taken), 32'(e_tk));
    chk(req, "next_pc", next_pc, e_nxt);
    chk(req, "link_we", 32'(link_we), 32'(e_we));
    chk(req, "link_idx", 32'(link_idx), 32'(e_idx));
    chk(req, "link_value", link_value, ds + 32'd4);
    chk(req, "addr_err", 32'(addr_err), 32'(e_err));
    chk(req, "bad_addr", bad_addr, e_bad);
  endtask

  task automatic t_reset;
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "taken", 32'(taken), 0);
    chk("R1", "next_pc", next_pc, 0);
    chk("R1", "link_we", 32'(link_we), 0);
    chk("R1", "addr_err", 32'(addr_err), 0);
    chk("R1", "link_value", link_value, 0);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    apply("R2", w_i(4, 0, 16'h0010), 32'h0000_1000, 32'd5, 32'd5);
    prev = next_pc;
    @(negedge clk);
    instr = w_i(2, 0, 16'hBEEF); ds_pc = 32'h1234_5670; rs_val = 0; in_valid = 1'b0;
    @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 0);
    chk("R2", "next_pc held", next_pc, prev);
  endtask

  task automatic t_decode;
    apply("R3", w_i(9, 0, 16'h0004), 32'h0000_2000, 32'd1, 32'd1);
    apply("R3", w_r(8, 0, 5'h15), 32'h0000_2000, 32'h0000_4000, 0);
    apply("R3", w_r(10, 6, 5'h0), 32'h0000_2000, 32'h0000_4000, 0);
    apply("R3", w_i(8, 0, 16'h0001), 32'h0000_2000, 0, 0);
  endtask

  task automatic t_rel;
    apply("R4", w_i(4, 0, 16'hFFF0), 32'h0000_0100, 32'hDEAD_0001, 32'hDEAD_0001);
    apply("R4", w_i(4, 0, 16'h7FFF), 32'hFFFF_FFF0, 32'd0, 32'd0);
  endtask

  task automatic t_abs;
    apply("R5", {6'd2, 26'h3FF_FFFF}, 32'hA000_0010, 0, 0);
    apply("R5", {6'd2, 26'h000_0040}, 32'h5FFF_FFFC, 0, 0);
  endtask

  task automatic t_link;
    apply("R6", {6'd3, 26'h012_3456}, 32'h8000_0200, 0, 0);
    apply("R6", w_i(1, 16, 16'h0008), 32'h0000_0300, 32'h0000_0001, 0);
    apply("R6", w_i(1, 17, 16'h0008), 32'h0000_0300, 32'h0000_0000, 0);
    apply("R6", w_i(1, 16, 16'h0008), 32'h0000_0300, 32'h8000_0000, 0);
  endtask

  task automatic t_jalr;
    apply("R7", w_r(9, 5, 5'h0), 32'h0000_0400, 32'h0000_8000, 0);
    apply("R7", w_r(9, 0, 5'h0), 32'h0000_0400, 32'h0000_8000, 0);
    apply("R7", w_r(8, 12, 5'h0), 32'h0000_0400, 32'h0000_9000, 0);
  endtask

  task automatic t_loose;
    apply("R8", w_i(1, 3, 16'h0020), 32'h0000_0500, 32'd0, 0);
    apply("R8", w_i(1, 18, 16'h0020), 32'h0000_0500, 32'hFFFF_FFFF, 0);
    apply("R8", w_i(1, 18, 16'h0020), 32'h0000_0500, 32'd7, 0);
    apply("R8", w_i(1, 31, 16'h0020), 32'h0000_0500, 32'h8000_0000, 0);
  endtask

  task automatic t_cmp;
    apply("R9", w_i(5, 0, 16'h0002), 32'h0000_0600, 32'h8000_0000, 32'h0000_0000);
    apply("R9", w_i(4, 0, 16'h0002), 32'h0000_0600, 32'h8000_0000, 32'h0000_0000);
    apply("R9", w_i(6, 0, 16'h0002), 32'h0000_0600, 32'h8000_0000, 0);
    apply("R9", w_i(6, 0, 16'h0002), 32'h0000_0600, 32'h0000_0000, 0);
    apply("R9", w_i(7, 0, 16'h0002), 32'h0000_0600, 32'h7FFF_FFFF, 0);
    apply("R9", w_i(7, 0, 16'h0002), 32'h0000_0600, 32'h0000_0000, 0);
  endtask

  task automatic t_fault;
    apply("R10", w_r(8, 0, 5'h0), 32'h0000_0700, 32'h0000_1002, 0);
    apply("R10", w_r(9, 7, 5'h0), 32'h0000_0700, 32'h0000_1001, 0);
    apply("R10", w_r(9, 7, 5'h0), 32'h0000_0700, 32'h0000_1000, 0);
  endtask

  task automatic t_fall;
    apply("R11", w_i(5, 0, 16'h0040), 32'hFFFF_FFFC, 32'd9, 32'd9);
    apply("R11", w_i(15, 0, 16'h1234), 32'h0000_0800, 0, 0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_decode();
    t_rel();
    t_abs();
    t_link();
    t_jalr();
    t_loose();
    t_cmp();
    t_fault();
    t_fall();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule